// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Interlock

This block sits in the decode stage of a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory and writeback. Operands are forwarded into decode, not into execute. For each of the two source operands of the instruction in decode, the block compares the source register index against the destinations of the instructions now in execute, memory and writeback. It then picks the value of the youngest matching producer. When no stage matches, it uses the register-file read data.

Load results are not ready until the load reaches writeback, because the data memory answers one clock after the request. A used source whose youngest producer is a load in execute or in memory therefore cannot be served. In that case the block raises a stall that holds fetch and decode, and it asks for a bubble in execute. The bubble is the no-op add x0, x0, x0. The stall lasts until the load has reached writeback. From there the load value is forwarded like any other result. The block is purely combinational and holds no state.

Top module: `hz_decode_bypass`

## Requirements
- R1: A source index of 0 always yields the value 0 on its operand output and never causes a stall, whatever the stage destinations or register-file data are.
- R2: When a valid (write-enable high) non-load instruction in execute writes the source register, that operand equals the execute result (distance one).
- R3: When the youngest valid match is in memory and it is not a load, the operand equals the memory-stage result (distance two).
- R4: When the only valid match is in writeback, the operand equals the writeback value (distance three). This holds whether or not that instruction is a load, and no stall follows.
- R5: With no valid match, the operand equals the register-file read data for that source.
- R6: When several stages write the same register, the youngest wins. Execute beats memory, memory beats writeback, and writeback beats the register file.
- R7: A stage with write-enable low is never a forwarding source and never causes a stall, even if its destination matches and its load flag is set.
- R8: When the youngest valid match for a used source is a load in execute or in memory, stall_fd and ex_bubble are both 1.
- R9: A source whose use flag is 0 never causes a stall.
- R10: The two operands are resolved independently. In the same cycle one may come from execute and the other from writeback.
- R11: With no load hazard (including a non-load in execute hiding an older load to the same register), stall_fd and ex_bubble are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | AW | First source register index of the decoded instruction |
| dec_src_b | input | AW | Second source register index of the decoded instruction |
| dec_use_a | input | 1 | First source is actually read by the decoded instruction |
| dec_use_b | input | 1 | Second source is actually read by the decoded instruction |
| ex_dst | input | AW | Destination index of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| ex_res | input | XLEN | Result produced by execute |
| mem_dst | input | AW | Destination index of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_load | input | 1 | Instruction in memory is a load |
| mem_res | input | XLEN | Result held in memory stage (not load data) |
| wb_dst | input | AW | Destination index of the instruction in writeback |
| wb_wen | input | 1 | Instruction in writeback writes a register |
| wb_res | input | XLEN | Value being written back (load data included) |
| rf_data_a | input | XLEN | Register-file read data for the first source |
| rf_data_b | input | XLEN | Register-file read data for the second source |
| opnd_a | output | XLEN | Resolved first operand |
| opnd_b | output | XLEN | Resolved second operand |
| stall_fd | output | 1 | Hold the fetch and decode stages this cycle |
| ex_bubble | output | 1 | Send the no-op into execute this cycle |

## Verification
The assertions assume that the inputs are settled, stable values at each check. They also assume that an instruction with its load flag set has its write-enable high whenever it matters. The flag-without-write-enable case is still driven to show it is ignored. The bench changes inputs only on the falling clock edge and samples one nanosecond later. Every input is therefore a defined constant whenever an output is compared. Each scenario starts from an idle pattern in which every write-enable is low, so no stale producer leaks into the next case.

// File: rtl/hz_pkg.sv
// Package: shared constants for the decode bypass unit.
// Assumes stage index 0 = execute, 1 = memory, 2 = writeback.
package hz_pkg;
    localparam int unsigned HZ_NSTG    = 3;  // producer stages checked
    localparam int unsigned HZ_STG_EX  = 0;
    localparam int unsigned HZ_STG_MEM = 1;
    localparam int unsigned HZ_STG_WB  = 2;
endpackage

// File: rtl/hz_match.sv
// Module: compares one source index against one producer destination.
// Assumes index 0 is the hardwired zero register and never a real producer.
module hz_match #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src_idx,
    input  logic [AW-1:0] dst_idx,
    input  logic          dst_wen,
    output logic          hit
);
    // A hit needs an enabled writer to the same non-zero register.
    always_comb begin
        hit = dst_wen && (src_idx == dst_idx) && (src_idx != '0);
    end
endmodule

// File: rtl/hz_operand_sel.sv
// Module: resolves one operand from the producer stages or the register file.
// Assumes stage 0 is youngest; only the last stage carries ready load data.
module hz_operand_sel #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned AW   = 5,
    parameter int unsigned NSTG = hz_pkg::HZ_NSTG
) (
    input  logic [AW-1:0]              src_idx,
    input  logic                       src_use,
    input  logic [NSTG-1:0][AW-1:0]    st_dst,
    input  logic [NSTG-1:0]            st_wen,
    input  logic [NSTG-1:0]            st_load,
    input  logic [NSTG-1:0][XLEN-1:0]  st_res,
    input  logic [XLEN-1:0]            rf_data,
    output logic [XLEN-1:0]            value,
    output logic                       hazard
);
    localparam int unsigned IW = (NSTG > 1) ? $clog2(NSTG) : 1;

    logic [NSTG-1:0] hit;
    logic [IW-1:0]   win_idx;
    logic            any_hit;

    // One comparator per producer stage.
    for (genvar g = 0; g < NSTG; g++) begin : g_cmp
        hz_match #(.AW(AW)) i_match (
            .src_idx (src_idx),
            .dst_idx (st_dst[g]),
            .dst_wen (st_wen[g]),
            .hit     (hit[g])
        );
    end

    // Pick the youngest hit by scanning oldest to youngest.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NSTG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                win_idx = i[IW-1:0];
            end
        end
    end

    // Drive the operand value and flag a not-yet-ready load.
    always_comb begin
        if (src_idx == '0) begin
            value = '0;
        end else if (any_hit) begin
            value = st_res[win_idx];
        end else begin
            value = rf_data;
        end
        hazard = src_use && any_hit && st_load[win_idx]
                 && (win_idx != IW'(NSTG - 1));
    end

    // a_r1_zero_src: the zero register gives zero and never interlocks.
    always_comb begin
        if (src_idx == '0) begin
            a_r1_zero_src: assert (value == '0 && !hazard)
                else $error("R1: zero source not zero or stalled");
        end
    end
endmodule

// File: rtl/hz_interlock.sv
// Module: merges per-operand hazards into the pipeline hold and bubble.
// Assumes the caller freezes fetch/decode and injects add x0,x0,x0 on ex_bubble.
module hz_interlock (
    input  logic haz_a,
    input  logic haz_b,
    output logic stall_fd,
    output logic ex_bubble
);
    // Either operand waiting on a load holds the front of the pipe.
    always_comb begin
        stall_fd  = haz_a || haz_b;
        ex_bubble = haz_a || haz_b;
    end
endmodule

// File: rtl/hz_decode_bypass.sv
// Module: decode-stage bypass and load interlock for a five-stage pipeline.
// Assumes load data is forwardable only from writeback; combinational, no state.
module hz_decode_bypass #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned AW   = 5
) (
    input  logic [AW-1:0]   dec_src_a,
    input  logic [AW-1:0]   dec_src_b,
    input  logic            dec_use_a,
    input  logic            dec_use_b,
    input  logic [AW-1:0]   ex_dst,
    input  logic            ex_wen,
    input  logic            ex_load,
    input  logic [XLEN-1:0] ex_res,
    input  logic [AW-1:0]   mem_dst,
    input  logic            mem_wen,
    input  logic            mem_load,
    input  logic [XLEN-1:0] mem_res,
    input  logic [AW-1:0]   wb_dst,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_res,
    input  logic [XLEN-1:0] rf_data_a,
    input  logic [XLEN-1:0] rf_data_b,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic            stall_fd,
    output logic            ex_bubble
);
    import hz_pkg::*;

    logic [HZ_NSTG-1:0][AW-1:0]   st_dst;
    logic [HZ_NSTG-1:0]           st_wen;
    logic [HZ_NSTG-1:0]           st_load;
    logic [HZ_NSTG-1:0][XLEN-1:0] st_res;
    logic                         haz_a;
    logic                         haz_b;

    // Gather producer stages into arrays, execute at index 0.
    always_comb begin
        st_dst[HZ_STG_EX]   = ex_dst;
        st_dst[HZ_STG_MEM]  = mem_dst;
        st_dst[HZ_STG_WB]   = wb_dst;
        st_wen[HZ_STG_EX]   = ex_wen;
        st_wen[HZ_STG_MEM]  = mem_wen;
        st_wen[HZ_STG_WB]   = wb_wen;
        st_load[HZ_STG_EX]  = ex_load;
        st_load[HZ_STG_MEM] = mem_load;
        st_load[HZ_STG_WB]  = 1'b0;
        st_res[HZ_STG_EX]   = ex_res;
        st_res[HZ_STG_MEM]  = mem_res;
        st_res[HZ_STG_WB]   = wb_res;
    end

    hz_operand_sel #(.XLEN(XLEN), .AW(AW), .NSTG(HZ_NSTG)) i_sel_a (
        .src_idx (dec_src_a),
        .src_use (dec_use_a),
        .st_dst  (st_dst),
        .st_wen  (st_wen),
        .st_load (st_load),
        .st_res  (st_res),
        .rf_data (rf_data_a),
        .value   (opnd_a),
        .hazard  (haz_a)
    );

    hz_operand_sel #(.XLEN(XLEN), .AW(AW), .NSTG(HZ_NSTG)) i_sel_b (
        .src_idx (dec_src_b),
        .src_use (dec_use_b),
        .st_dst  (st_dst),
        .st_wen  (st_wen),
        .st_load (st_load),
        .st_res  (st_res),
        .rf_data (rf_data_b),
        .value   (opnd_b),
        .hazard  (haz_b)
    );

    hz_interlock i_lock (
        .haz_a     (haz_a),
        .haz_b     (haz_b),
        .stall_fd  (stall_fd),
        .ex_bubble (ex_bubble)
    );

    // Port-level checks on forwarding and interlock causes.
    always_comb begin
        if (ex_wen && !ex_load && dec_src_a == ex_dst && dec_src_a != '0) begin
            a_r2_ex_forward: assert (opnd_a == ex_res)
                else $error("R2: execute result not forwarded");
        end
        if (stall_fd) begin
            a_r9_stall_needs_use: assert ((dec_use_a && dec_src_a != '0) ||
                                          (dec_use_b && dec_src_b != '0))
                else $error("R9: stall without a used source");
            a_r11_stall_needs_load: assert ((ex_wen && ex_load) ||
                                            (mem_wen && mem_load))
                else $error("R11: stall without a pending load");
        end
    end
endmodule

// File: tb/test_hz_decode_bypass.sv
module test_hz_decode_bypass;
    localparam int unsigned XLEN = 32;
    localparam int unsigned AW   = 5;
    localparam logic [XLEN-1:0] VEX  = 32'hE0E0_0001;
    localparam logic [XLEN-1:0] VMEM = 32'hA0A0_0002;
    localparam logic [XLEN-1:0] VWB  = 32'hB0B0_0003;
    localparam logic [XLEN-1:0] VRFA = 32'h1111_1111;
    localparam logic [XLEN-1:0] VRFB = 32'h2222_2222;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
    logic use_a, use_b, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [XLEN-1:0] ex_res, mem_res, wb_res, rf_a, rf_b, op_a, op_b;
    logic stall, bubble;
    int total = 0;
    int bad = 0;

    hz_decode_bypass #(.XLEN(XLEN), .AW(AW)) i_hz_decode_bypass (
        .dec_src_a(src_a), .dec_src_b(src_b), .dec_use_a(use_a), .dec_use_b(use_b),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .ex_res(ex_res),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load), .mem_res(mem_res),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_res(wb_res),
        .rf_data_a(rf_a), .rf_data_b(rf_b),
        .opnd_a(op_a), .opnd_b(op_b), .stall_fd(stall), .ex_bubble(bubble)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Idle pattern: no writers, sources 3 and 4 used.
    task automatic idle();
        @(negedge clk);
        src_a = 5'd3; src_b = 5'd4; use_a = 1'b1; use_b = 1'b1;
        ex_dst = 5'd0; mem_dst = 5'd0; wb_dst = 5'd0;
        ex_wen = 1'b0; mem_wen = 1'b0; wb_wen = 1'b0;
        ex_load = 1'b0; mem_load = 1'b0;
        ex_res = VEX; mem_res = VMEM; wb_res = VWB; rf_a = VRFA; rf_b = VRFB;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_idle();
        idle(); settle();
        chk("R5 opnd_a", op_a, VRFA);
        chk("R5 opnd_b", op_b, VRFB);
        chk("R11 stall", {31'd0, stall}, 32'd0);
        chk("R11 bubble", {31'd0, bubble}, 32'd0);
    endtask

    task automatic t_distances();
        idle(); ex_dst = 5'd3; ex_wen = 1'b1; settle();
        chk("R2 dist1", op_a, VEX);
        idle(); mem_dst = 5'd3; mem_wen = 1'b1; settle();
        chk("R3 dist2", op_a, VMEM);
        idle(); wb_dst = 5'd4; wb_wen = 1'b1; settle();
        chk("R4 dist3", op_b, VWB);
        chk("R4 no stall", {31'd0, stall}, 32'd0);
    endtask

    task automatic t_priority();
        idle(); src_a = 5'd5;
        ex_dst = 5'd5; mem_dst = 5'd5; wb_dst = 5'd5;
        ex_wen = 1'b1; mem_wen = 1'b1; wb_wen = 1'b1; settle();
        chk("R6 ex wins", op_a, VEX);
        @(negedge clk); ex_wen = 1'b0; settle();
        chk("R6 mem wins", op_a, VMEM);
        @(negedge clk); mem_wen = 1'b0; settle();
        chk("R6 wb wins", op_a, VWB);
        @(negedge clk); wb_wen = 1'b0; settle();
        chk("R7 we low -> rf", op_a, VRFA);
    endtask

    task automatic t_zero();
        idle(); src_a = 5'd0; src_b = 5'd0; rf_a = 32'hDEAD_BEEF;
        ex_dst = 5'd0; ex_wen = 1'b1; ex_load = 1'b1;
        mem_dst = 5'd0; mem_wen = 1'b1; settle();
        chk("R1 opnd_a zero", op_a, 32'd0);
        chk("R1 opnd_b zero", op_b, 32'd0);
        chk("R1 no stall", {31'd0, stall}, 32'd0);
    endtask

    task automatic t_loads();
        idle(); ex_dst = 5'd3; ex_wen = 1'b1; ex_load = 1'b1; settle();
        chk("R8 load ex stall", {31'd0, stall}, 32'd1);
        chk("R8 load ex bubble", {31'd0, bubble}, 32'd1);
        idle(); mem_dst = 5'd4; mem_wen = 1'b1; mem_load = 1'b1; settle();
        chk("R8 load mem stall", {31'd0, stall}, 32'd1);
        chk("R8 load mem bubble", {31'd0, bubble}, 32'd1);
        idle(); wb_dst = 5'd3; wb_wen = 1'b1; settle();
        chk("R4 load wb value", op_a, VWB);
        chk("R4 load wb no stall", {31'd0, stall}, 32'd0);
        idle(); ex_dst = 5'd3; ex_wen = 1'b0; ex_load = 1'b1; settle();
        chk("R7 load we low no stall", {31'd0, stall}, 32'd0);
        chk("R7 load we low value", op_a, VRFA);
    endtask

    task automatic t_unused();
        idle(); use_a = 1'b0; ex_dst = 5'd3; ex_wen = 1'b1; ex_load = 1'b1; settle();
        chk("R9 unused a", {31'd0, stall}, 32'd0);
        idle(); use_b = 1'b0; mem_dst = 5'd4; mem_wen = 1'b1; mem_load = 1'b1; settle();
        chk("R9 unused b", {31'd0, bubble}, 32'd0);
    endtask

    task automatic t_two_sources();
        idle(); src_a = 5'd6; src_b = 5'd7;
        ex_dst = 5'd6; ex_wen = 1'b1; wb_dst = 5'd7; wb_wen = 1'b1; settle();
        chk("R10 a from ex", op_a, VEX);
        chk("R10 b from wb", op_b, VWB);
        idle(); src_a = 5'd6; src_b = 5'd7;
        mem_dst = 5'd7; mem_wen = 1'b1; wb_dst = 5'd6; wb_wen = 1'b1; settle();
        chk("R10 a from wb", op_a, VWB);
        chk("R10 b from mem", op_b, VMEM);
    endtask

    task automatic t_shadow();
        idle(); ex_dst = 5'd3; ex_wen = 1'b1;
        mem_dst = 5'd3; mem_wen = 1'b1; mem_load = 1'b1; settle();
        chk("R11 shadowed load value", op_a, VEX);
        chk("R11 shadowed load stall", {31'd0, stall}, 32'd0);
    endtask

    initial begin
        fork
            begin
                t_idle();
                t_distances();
                t_priority();
                t_zero();
                t_loads();
                t_unused();
                t_two_sources();
                t_shadow();
            end
            begin
                repeat (2000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule